// File: doc/BRIEF.md
# Vector Element Order Reverser

This unit takes a 64-bit or 128-bit vector operand and mirrors the order of its elements inside containers of a chosen size, leaving the bytes within each element in their original order. Elements may be 8, 16 or 32 bits wide. Containers may be 16, 32 or 64 bits wide. With 8-bit elements in 64-bit containers the result is a byte swap of each 64-bit half.

The container size comes from two instruction bits read together as a 2-bit code. The element size comes from a separate 2-bit code. An element must be smaller than its container, so combinations that break this rule are flagged as illegal and give a zero result. When the narrow (64-bit) form is selected, only the lower half is processed and the upper half of the result is zero. The result is registered and appears one clock after the request.

Top module: `vec_elem_rev`

## Requirements
- R1: One cycle after `rst` is sampled high, `out_valid`, `bad_enc` and `out_vec` are all zero.
- R2: `out_valid` is high in exactly the cycle that follows a cycle in which `in_valid` was high.
- R3: The element width is 8 << `elem_sz` bits. The container code is {`op_hi`, `variant`}. Code 0 gives 64-bit containers, code 1 gives 32-bit containers and code 2 gives 16-bit containers.
- R4: When the container code plus `elem_sz` is 3 or more, the registered result has `bad_enc` high and `out_vec` all zero. This always covers container code 3 and `elem_sz` 3.
- R5: For a legal request, element i of the source (numbered from bit 0 upward, each element of the element width) is written to the element position in the same container whose offset from the container's first element is (elements per container − 1 − offset of i).
- R6: When `full_q` is 0, bits 127:64 of the result are zero and only bits 63:0 of the source are used.
- R7: When `full_q` is 1, both 64-bit halves are reversed, and no element crosses between the halves.
- R8: With `elem_sz` 0 and container code 0, each processed 64-bit half of the result is the byte-swapped source half.
- R9: `bad_enc` is low on every legal request. In a cycle after `in_valid` was low, `out_vec` and `bad_enc` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_vec | input | 128 | Source vector |
| elem_sz | input | 2 | Element size code |
| op_hi | input | 1 | Upper bit of the container code |
| variant | input | 1 | Lower bit of the container code |
| full_q | input | 1 | 1 selects the 128-bit form, 0 the 64-bit form |
| out_valid | output | 1 | Result strobe |
| out_vec | output | 128 | Reversed vector |
| bad_enc | output | 1 | Illegal size/container combination |

## Verification
Illegal-encoding suppression and the narrow-form zeroing of the upper half can both act on the same result. The bench sends every illegal size/container pair with random data under both `full_q` values, back to back with legal requests. It expects an all-zero vector with `bad_enc` high whatever `full_q` is. For legal narrow requests it expects the upper half to be zero while the lower half is still reversed. The expected vectors come from a reference in the bench that loops over elements and containers.

// File: rtl/rev_pkg.sv
package rev_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic       legal;
    logic [2:0] byte_mask;
  } rev_ctl_t;
endpackage

// File: rtl/rev_decode.sv
// Decodes the container code and element size into a legality flag and a
// byte-index XOR mask that is applied within each 64-bit half.
module rev_decode
  import rev_pkg::*;
(
  input  logic [1:0] elem_sz,
  input  logic       op_hi,
  input  logic       variant,
  output rev_ctl_t   ctl
);
  logic [1:0] cont_code;
  logic [2:0] span_sum;
  logic [2:0] elem_mask;

  assign cont_code = {op_hi, variant};
  assign span_sum  = {1'b0, cont_code} + {1'b0, elem_sz};

  // Element index mask: (1 << (3 - sum)) - 1 for a legal sum.
  always_comb begin
    case (span_sum)
      3'd0:    elem_mask = 3'b111;
      3'd1:    elem_mask = 3'b011;
      3'd2:    elem_mask = 3'b001;
      default: elem_mask = 3'b000;
    endcase
  end

  assign ctl.legal     = (span_sum < 3'd3);
  assign ctl.byte_mask = elem_mask << elem_sz;
endmodule

// File: rtl/rev_permute.sv
// Byte-level permutation: destination byte at position p in a half takes
// source byte p ^ byte_mask of the same half. Halves above the first are
// zeroed in the narrow form, and everything is zeroed when killed.
module rev_permute
  import rev_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int HALF_W = 64
) (
  input  logic [VEC_W-1:0]                     src_vec,
  input  logic [$clog2(HALF_W/BYTE_W)-1:0]     byte_mask,
  input  logic                                 full_q,
  input  logic                                 kill,
  output logic [VEC_W-1:0]                     dst_vec
);
  localparam int NBYTES     = VEC_W / BYTE_W;
  localparam int LANE_BYTES = HALF_W / BYTE_W;
  localparam int MW         = $clog2(LANE_BYTES);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    localparam int LANE = g / LANE_BYTES;
    localparam int POS  = g % LANE_BYTES;
    localparam int BASE = LANE * LANE_BYTES;
    logic [BYTE_W-1:0] pick;

    always_comb begin
      pick = '0;
      for (int m = 0; m < LANE_BYTES; m++) begin
        if (byte_mask == MW'(m))
          pick = src_vec[(BASE + (POS ^ m))*BYTE_W +: BYTE_W];
      end
    end

    if (LANE == 0) begin : g_low
      assign dst_vec[g*BYTE_W +: BYTE_W] = kill ? '0 : pick;
    end else begin : g_high
      assign dst_vec[g*BYTE_W +: BYTE_W] = (kill || !full_q) ? '0 : pick;
    end
  end
endmodule

// File: rtl/vec_elem_rev.sv
module vec_elem_rev
  import rev_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int HALF_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [1:0]       elem_sz,
  input  logic             op_hi,
  input  logic             variant,
  input  logic             full_q,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_vec,
  output logic             bad_enc
);
  localparam int MW = $clog2(HALF_W / BYTE_W);

  rev_ctl_t         ctl;
  logic [VEC_W-1:0] perm_vec;

  rev_decode u_dec (
    .elem_sz (elem_sz),
    .op_hi   (op_hi),
    .variant (variant),
    .ctl     (ctl)
  );

  rev_permute #(.VEC_W(VEC_W), .HALF_W(HALF_W)) u_perm (
    .src_vec   (src_vec),
    .byte_mask (ctl.byte_mask[MW-1:0]),
    .full_q    (full_q),
    .kill      (!ctl.legal),
    .dst_vec   (perm_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
      bad_enc   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_vec <= perm_vec;
        bad_enc <= !ctl.legal;
      end
    end
  end
endmodule

// File: rtl/vec_elem_rev_chk.sv
module vec_elem_rev_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [VEC_W-1:0] src_vec,
  input logic [1:0]       elem_sz,
  input logic             op_hi,
  input logic             variant,
  input logic             full_q,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_vec,
  input logic             bad_enc
);
  logic [2:0] sum_q;
  assign sum_q = {1'b0, op_hi, variant} + {1'b0, elem_sz};

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !bad_enc && out_vec == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R4
  bad_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sum_q >= 3'd3) |=> bad_enc);

  // R4
  bad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && bad_enc) |-> (out_vec == '0));

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !full_q) |=> (out_vec[VEC_W-1:VEC_W/2] == '0));

  // R9
  legal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sum_q < 3'd3) |=> !bad_enc);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_vec) && $stable(bad_enc)));
endmodule

bind vec_elem_rev vec_elem_rev_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/vec_elem_rev_bench.sv
module vec_elem_rev_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [127:0] src_vec;
  logic [1:0]   elem_sz;
  logic         op_hi;
  logic         variant;
  logic         full_q;
  logic         out_valid;
  logic [127:0] out_vec;
  logic         bad_enc;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  vec_elem_rev u_vec_elem_rev (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
    .elem_sz(elem_sz), .op_hi(op_hi), .variant(variant), .full_q(full_q),
    .out_valid(out_valid), .out_vec(out_vec), .bad_enc(bad_enc)
  );

  task automatic chk(input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: element loop over containers (R3, R5, R6, R7).
  function automatic logic [127:0] ref_rev(input logic [127:0] s,
      input int sz, input int code, input bit q);
    logic [127:0] r = '0;
    int esz  = 8 << sz;
    int cont = 64 >> code;
    int per  = cont / esz;
    int n    = (q ? 128 : 64) / esz;
    for (int i = 0; i < n; i++) begin
      int base = (i / per) * per;
      int d    = base + (per - 1 - (i % per));
      for (int k = 0; k < esz; k++) r[d*esz + k] = s[i*esz + k];
    end
    return r;
  endfunction

  function automatic logic [127:0] bswap(input logic [127:0] s, input bit q);
    logic [127:0] r = '0;
    for (int b = 0; b < 8; b++) begin
      r[8*b +: 8] = s[8*(7-b) +: 8];
      if (q) r[64 + 8*b +: 8] = s[64 + 8*(7-b) +: 8];
    end
    return r;
  endfunction

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] last_vec;
    logic         last_bad;
    rst = 1'b1; in_valid = 0; src_vec = '1; elem_sz = 0;
    op_hi = 0; variant = 0; full_q = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {125'b0, out_valid, bad_enc, 1'b0}, '0);
    chk("R1", out_vec, '0);
    rst = 1'b0;

    for (int sz = 0; sz < 4; sz++)
      for (int code = 0; code < 4; code++)
        for (int q = 0; q < 2; q++)
          for (int rep = 0; rep < 6; rep++) begin
            logic [127:0] s;
            logic [127:0] exp;
            bit illegal;
            s = {$urandom, $urandom, $urandom, $urandom};
            illegal = (sz + code) >= 3;
            in_valid = 1; src_vec = s; elem_sz = 2'(sz);
            {op_hi, variant} = 2'(code); full_q = q[0];
            @(negedge clk);
            // R2
            chk("R2", {127'b0, out_valid}, 128'd1);
            if (illegal) begin
              // R4: flag and zero result, either Q value
              chk("R4", {127'b0, bad_enc}, 128'd1);
              chk("R4", out_vec, '0);
            end else begin
              exp = ref_rev(s, sz, code, q[0]);
              // R9: legal leaves flag low
              chk("R9", {127'b0, bad_enc}, '0);
              // R5 (R6 narrow, R7 wide)
              chk(q ? "R5/R7" : "R5/R6", out_vec, exp);
              if (!q) chk("R6", {64'b0, out_vec[127:64]}, '0);
              if (sz == 0 && code == 0) chk("R8", out_vec, bswap(s, q[0]));
            end
          end

    // R2 / R9: idle cycles hold the result
    last_vec = out_vec; last_bad = bad_enc;
    in_valid = 0; src_vec = ~src_vec; elem_sz = 2'd0; {op_hi, variant} = 2'd0;
    @(negedge clk);
    chk("R2", {127'b0, out_valid}, '0);
    chk("R9", out_vec, last_vec);
    chk("R9", {127'b0, bad_enc}, {127'b0, last_bad});
    @(negedge clk);
    chk("R9", out_vec, last_vec);

    // R1: reset mid-run clears outputs
    in_valid = 1; src_vec = {4{32'hA5C3_1F0E}};
    rst = 1;
    @(negedge clk);
    chk("R1", {126'b0, out_valid, bad_enc}, '0);
    chk("R1", out_vec, '0);
    rst = 0; in_valid = 0;
    @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule